// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns one parallel pixel word per pixel clock into three bit-serial data lanes and one forwarded clock lane, each running at seven bits per pixel period. The parallel word holds 18 colour bits and three panel timing bits (line sync, frame sync, data enable). It is captured on a pixel-clock edge chosen by a static select input. The word then crosses into the bit-clock domain through a pair of alternating slots and is shifted out, most significant bit of each 7-bit slice first. The clock lane carries a fixed 7-bit pattern in the same frame as the data.

Two conditions force every lane low. The first is the active-low power-down input, which also clears all state. The second is a pixel-clock presence monitor running on the bit clock. It declares the pixel clock lost after a long enough gap, and it declares the clock present again only after two pixel edges in a row. The bit clock must run at exactly seven times the pixel clock. The differential line drivers and the clock multiplier are outside the block.

Top module: `pixel_link_serializer`

## Requirements
- R1: The parallel word is {data_en, frame_sync, line_sync, color[17:0]} (bit 20 down to bit 0). Data lane i carries word bits [7i+6:7i], and the most significant bit of that slice is sent first.
- R2: A word's frame starts at the third clk_bit rising edge after the pixel rising edge that writes it into the transfer slots. The frame lasts exactly seven clk_bit cycles, one bit per cycle on every lane.
- R3: Within each frame, lane_clk carries the pattern 1100011, sent left to right, aligned with the data bits.
- R4: When edge_sel is 1, the word is sampled on the rising pixel edge. When edge_sel is 0, it is sampled on the falling edge and handed over at the following rising edge. A change of the inputs after the selected edge does not alter the word that is sent.
- R5: While pwr_on is 0, all four lanes are 0 and all state is cleared. After pwr_on returns to 1, the frame of the first pixel edge stays all zero and the frame of the second edge carries its word.
- R6: When no pixel rising edge is seen for 16 consecutive clk_bit cycles, the pixel clock is treated as lost and all lanes are held at 0.
- R7: A lost pixel clock counts as present again only after two consecutive pixel rising edges. The frame of the first edge is all zero, and the frame of the second edge carries its word and clock pattern. An edge seen while the clock is present never makes it lost.
- R8: While rst_n is 0, all lanes are 0, and after reset the pixel clock is treated as lost.
- R9: Words handed over on consecutive pixel edges are sent in consecutive frames, each one whole and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel clock |
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Active-low power-down: 0 holds the lanes low and clears state |
| edge_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| color | input | 18 | Colour bits, word bits [17:0] |
| line_sync | input | 1 | Line sync, word bit 18 |
| frame_sync | input | 1 | Frame sync, word bit 19 |
| data_en | input | 1 | Data enable, word bit 20 |
| lane_data | output | 3 | Serial data lanes |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
The assertions take the bit clock to run at exactly seven times the pixel clock. They also take pixel rising edges to lie clear of bit-clock edges, and pwr_on and rst_n to be released only while the pixel clock is low, so that a release is never mistaken for a pixel edge. The bench makes the pixel clock by gating a free-running clock with that fixed ratio and a 4 ns lead over the next bit-clock edge. It changes the gate only while that clock is low, and it releases reset and power-down 3 ns after a falling pixel edge. Data changes 2 ns after the edge opposite the sampling edge, which keeps setup and hold on the capture edge.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;

  // Presence monitor states: lost, one edge seen while lost, present.
  typedef enum logic [1:0] {
    MON_LOST     = 2'd0,
    MON_ONE_EDGE = 2'd1,
    MON_OK       = 2'd2
  } mon_state_e;

  // Clock-lane level at send position k (k = 0 goes out first) of a w-bit frame.
  function automatic logic clk_lane_level(input int unsigned w, input int unsigned k);
    int unsigned run_len;
    run_len = (w - 3) / 2;
    return (k < run_len) || (k >= w - run_len);
  endfunction

  // Word bit index sent on a lane at send position k.
  function automatic int unsigned lane_bit_index(input int unsigned lane, input int unsigned w,
                                                 input int unsigned k);
    return lane * w + (w - 1 - k);
  endfunction

endpackage

// File: rtl/pls_capture.sv
`timescale 1ns/1ps
module pls_capture #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk_pix,
  input  logic              clr_n,
  input  logic              edge_sel,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] slot0_o,
  output logic [WORD_W-1:0] slot1_o,
  output logic              wp_o
);
  logic [WORD_W-1:0] fall_q;
  logic              fall_vld;
  logic              wr_en;
  logic [WORD_W-1:0] wr_word;
  logic              wp_q;
  logic [WORD_W-1:0] slot_q [2];

  // Falling-edge sample register, valid once one falling edge has passed.
  always_ff @(negedge clk_pix or negedge clr_n) begin
    if (!clr_n) begin
      fall_q   <= '0;
      fall_vld <= 1'b0;
    end else begin
      fall_q   <= word_i;
      fall_vld <= 1'b1;
    end
  end

  always_comb begin
    wr_en   = edge_sel | fall_vld;
    wr_word = edge_sel ? word_i : fall_q;
  end

  // Alternating slots: each slot stays untouched for a full pixel period after its write.
  always_ff @(posedge clk_pix or negedge clr_n) begin
    if (!clr_n) begin
      slot_q[0] <= '0;
      slot_q[1] <= '0;
      wp_q      <= 1'b0;
    end else if (wr_en) begin
      slot_q[wp_q] <= wr_word;
      wp_q         <= ~wp_q;
    end
  end

  assign slot0_o = slot_q[0];
  assign slot1_o = slot_q[1];
  assign wp_o    = wp_q;
endmodule

// File: rtl/pls_clk_monitor.sv
`timescale 1ns/1ps
module pls_clk_monitor #(
  parameter int unsigned GAP_LIMIT = 16
) (
  input  logic clk_bit,
  input  logic clr_n,
  input  logic clk_pix,
  output logic pix_rise_o,
  output logic missing_q_o,
  output logic missing_nx_o
);
  import pls_pkg::*;

  localparam int unsigned GW      = $clog2(GAP_LIMIT + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(GAP_LIMIT);

  logic [2:0]    pix_sync;
  logic          pix_rise;
  logic [GW-1:0] gap_q, gap_nx;
  mon_state_e    st_q, st_nx;

  always_ff @(posedge clk_bit or negedge clr_n) begin
    if (!clr_n) pix_sync <= '0;
    else        pix_sync <= {pix_sync[1:0], clk_pix};
  end

  assign pix_rise = pix_sync[1] & ~pix_sync[2];

  always_comb begin
    gap_nx = gap_q;
    st_nx  = st_q;
    if (pix_rise) begin
      gap_nx = '0;
      case (st_q)
        MON_LOST: st_nx = MON_ONE_EDGE;
        default:  st_nx = MON_OK;
      endcase
    end else begin
      if (gap_q != GAP_MAX) gap_nx = gap_q + 1'b1;
      if (gap_nx == GAP_MAX) st_nx = MON_LOST;
    end
  end

  always_ff @(posedge clk_bit or negedge clr_n) begin
    if (!clr_n) begin
      gap_q <= GAP_MAX;
      st_q  <= MON_LOST;
    end else begin
      gap_q <= gap_nx;
      st_q  <= st_nx;
    end
  end

  assign pix_rise_o   = pix_rise;
  assign missing_q_o  = (st_q != MON_OK);
  assign missing_nx_o = (st_nx != MON_OK);
endmodule

// File: rtl/pls_lane_shifter.sv
`timescale 1ns/1ps
module pls_lane_shifter #(
  parameter int unsigned SLICE_W = 7
) (
  input  logic               clk_bit,
  input  logic               clr_n,
  input  logic               load_i,
  input  logic               kill_i,
  input  logic [SLICE_W-1:0] slice_i,
  output logic               bit_o
);
  localparam int unsigned CW = $clog2(SLICE_W + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(SLICE_W);

  logic [SLICE_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q;
  logic               bit_q;

  always_ff @(posedge clk_bit or negedge clr_n) begin
    if (!clr_n) begin
      sh_q  <= '0;
      cnt_q <= CNT_DONE;
      bit_q <= 1'b0;
    end else if (load_i) begin
      bit_q <= slice_i[SLICE_W-1] & ~kill_i;
      sh_q  <= {slice_i[SLICE_W-2:0], 1'b0};
      cnt_q <= CW'(1);
    end else if (cnt_q != CNT_DONE) begin
      bit_q <= sh_q[SLICE_W-1] & ~kill_i;
      sh_q  <= {sh_q[SLICE_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end else begin
      bit_q <= 1'b0;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/pixel_link_serializer.sv
`timescale 1ns/1ps
module pixel_link_serializer #(
  parameter int unsigned SLICE_W    = 7,
  parameter int unsigned DATA_LANES = 3,
  parameter int unsigned COLOR_W    = 18,
  parameter int unsigned GAP_LIMIT  = 16
) (
  input  logic                  clk_bit,
  input  logic                  clk_pix,
  input  logic                  rst_n,
  input  logic                  pwr_on,
  input  logic                  edge_sel,
  input  logic [COLOR_W-1:0]    color,
  input  logic                  line_sync,
  input  logic                  frame_sync,
  input  logic                  data_en,
  output logic [DATA_LANES-1:0] lane_data,
  output logic                  lane_clk
);
  localparam int unsigned WORD_W = SLICE_W * DATA_LANES;

  logic                  clr_n;
  logic [WORD_W-1:0]     word_in;
  logic [WORD_W-1:0]     slot0, slot1, rd_word;
  logic                  wp_pix;
  logic [2:0]            wp_sync;
  logic                  frame_load;
  logic                  pix_rise;
  logic                  clk_missing_q, clk_missing_nx;
  logic [SLICE_W-1:0]    clk_pat;
  logic [DATA_LANES-1:0] load_msbs;

  assign clr_n   = rst_n & pwr_on;
  assign word_in = WORD_W'({data_en, frame_sync, line_sync, color});

  pls_capture #(.WORD_W(WORD_W)) u_capture (
    .clk_pix (clk_pix),
    .clr_n   (clr_n),
    .edge_sel(edge_sel),
    .word_i  (word_in),
    .slot0_o (slot0),
    .slot1_o (slot1),
    .wp_o    (wp_pix)
  );

  // Only the slot pointer crosses; the slot it names is stable while read.
  always_ff @(posedge clk_bit or negedge clr_n) begin
    if (!clr_n) wp_sync <= '0;
    else        wp_sync <= {wp_sync[1:0], wp_pix};
  end

  assign frame_load = wp_sync[1] ^ wp_sync[2];
  assign rd_word    = wp_sync[2] ? slot1 : slot0;

  pls_clk_monitor #(.GAP_LIMIT(GAP_LIMIT)) u_monitor (
    .clk_bit     (clk_bit),
    .clr_n       (clr_n),
    .clk_pix     (clk_pix),
    .pix_rise_o  (pix_rise),
    .missing_q_o (clk_missing_q),
    .missing_nx_o(clk_missing_nx)
  );

  for (genvar k = 0; k < SLICE_W; k++) begin : g_pat
    assign clk_pat[SLICE_W-1-k] = pls_pkg::clk_lane_level(SLICE_W, k);
  end

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
    assign load_msbs[i] = rd_word[pls_pkg::lane_bit_index(i, SLICE_W, 0)];
    pls_lane_shifter #(.SLICE_W(SLICE_W)) u_shift (
      .clk_bit(clk_bit),
      .clr_n  (clr_n),
      .load_i (frame_load),
      .kill_i (clk_missing_nx),
      .slice_i(rd_word[i*SLICE_W +: SLICE_W]),
      .bit_o  (lane_data[i])
    );
  end

  pls_lane_shifter #(.SLICE_W(SLICE_W)) u_clk_shift (
    .clk_bit(clk_bit),
    .clr_n  (clr_n),
    .load_i (frame_load),
    .kill_i (clk_missing_nx),
    .slice_i(clk_pat),
    .bit_o  (lane_clk)
  );
endmodule

// File: rtl/pls_checker.sv
`timescale 1ns/1ps
module pls_checker #(
  parameter int unsigned DATA_LANES = 3
) (
  input logic                  clk_bit,
  input logic                  rst_n,
  input logic                  pwr_on,
  input logic                  frame_load,
  input logic                  pix_rise,
  input logic                  missing_q,
  input logic                  missing_nx,
  input logic [DATA_LANES-1:0] load_msbs,
  input logic [DATA_LANES-1:0] lane_data,
  input logic                  lane_clk
);
  // R5
  pwr_down_low_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pwr_on |-> (lane_data == '0 && !lane_clk));

  // R6
  lost_low_chk: assert property (@(posedge clk_bit) disable iff (!rst_n || !pwr_on)
    missing_nx |=> (lane_data == '0 && !lane_clk));

  // R6
  lost_needs_gap_chk: assert property (@(posedge clk_bit) disable iff (!rst_n || !pwr_on)
    $rose(missing_q) |-> !$past(pix_rise));

  // R7
  edge_keeps_present_chk: assert property (@(posedge clk_bit) disable iff (!rst_n || !pwr_on)
    (pix_rise && !missing_q) |=> !missing_q);

  // R1
  first_bit_chk: assert property (@(posedge clk_bit) disable iff (!rst_n || !pwr_on)
    (frame_load && !missing_nx) |=> (lane_data == $past(load_msbs)));

  // R3
  clk_first_high_chk: assert property (@(posedge clk_bit) disable iff (!rst_n || !pwr_on)
    (frame_load && !missing_nx) |=> lane_clk);

  // R2
  single_load_chk: assert property (@(posedge clk_bit) disable iff (!rst_n || !pwr_on)
    frame_load |=> !frame_load);
endmodule

bind pixel_link_serializer pls_checker #(.DATA_LANES(DATA_LANES)) u_pls_checker (
  .clk_bit   (clk_bit),
  .rst_n     (rst_n),
  .pwr_on    (pwr_on),
  .frame_load(frame_load),
  .pix_rise  (pix_rise),
  .missing_q (clk_missing_q),
  .missing_nx(clk_missing_nx),
  .load_msbs (load_msbs),
  .lane_data (lane_data),
  .lane_clk  (lane_clk)
);

// File: tb/pixel_link_serializer_bench.sv
`timescale 1ns/1ps
module pixel_link_serializer_bench;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk_bit = 1'b0;
  logic        clk_raw = 1'b0;
  logic        pix_run = 1'b1;
  logic        clk_pix;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b1;
  logic        edge_sel = 1'b1;
  logic [20:0] din = '0;
  logic [2:0]  lane_data;
  logic        lane_clk;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk_bit = ~clk_bit;
  initial begin
    #1;
    forever #17.5 clk_raw = ~clk_raw;
  end
  assign clk_pix = clk_raw & pix_run;

  pixel_link_serializer u_pixel_link_serializer (
    .clk_bit   (clk_bit),
    .clk_pix   (clk_pix),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .edge_sel  (edge_sel),
    .color     (din[17:0]),
    .line_sync (din[18]),
    .frame_sync(din[19]),
    .data_en   (din[20]),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
  );

  function automatic logic [20:0] pack(input logic [17:0] c, input logic ls, input logic fs,
                                       input logic de);
    return {de, fs, ls, c};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", what, got, exp);
    end
  endtask

  task automatic check_low(input string what);
    check(lane_data == 3'b000 && lane_clk == 1'b0, what, {28'd0, lane_clk, lane_data}, 32'd0);
  endtask

  // Samples seven bit periods; first is the delay to the middle of bit 0.
  task automatic check_frame(input logic [20:0] exp_w, input logic [6:0] exp_c,
                             input realtime first, input string tag);
    logic [20:0] gw;
    logic [6:0]  gc;
    gw = '0;
    gc = '0;
    for (int k = 0; k < 7; k++) begin
      if (k == 0) #(first);
      else #5.0;
      for (int i = 0; i < 3; i++) gw[i*7+6-k] = lane_data[i];
      gc[6-k] = lane_clk;
    end
    check(gw == exp_w, {tag, " data lanes"}, 32'(gw), 32'(exp_w));
    check(gc == exp_c, {tag, " clock lane"}, 32'(gc), 32'(exp_c));
  endtask

  // Four words on consecutive pixel periods; the inputs are garbled after each capture edge.
  task automatic run_stream(input bit fall, input logic [20:0] ws [4], input string tag);
    fork
      begin
        for (int i = 0; i < 4; i++) begin
          if (!fall) begin
            @(negedge clk_pix); #2 din = ws[i];
            @(posedge clk_pix); #2 din = ~ws[i];
          end else begin
            @(posedge clk_pix); #2 din = ws[i];
            @(negedge clk_pix); #2 din = ~ws[i];
          end
        end
      end
      begin
        if (!fall) begin
          @(negedge clk_pix);
          @(posedge clk_pix);
        end else begin
          @(posedge clk_pix);
          @(posedge clk_pix);
        end
        for (int i = 0; i < 4; i++)
          check_frame(ws[i], PAT, (i == 0) ? 16.5 : 5.0, tag);
      end
    join
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk_pix);
    #1 check_low("R8 lanes low in reset");
    #7 check_low("R8 lanes low in reset later");
    @(negedge clk_pix); #3 rst_n = 1'b1;
    @(posedge clk_pix);
    check_frame('0, 7'd0, 16.5, "R8 first edge after reset");
  endtask

  task automatic test_rising_a();
    run_stream(1'b0, '{pack(18'h2AAAA, 1'b1, 1'b0, 1'b1), pack(18'h15555, 1'b0, 1'b1, 1'b0),
                      pack(18'h3F00F, 1'b1, 1'b1, 1'b1), pack(18'h00FF0, 1'b0, 1'b0, 1'b0)},
               "R1 R2 R3 R9 rising stream A");
  endtask

  task automatic test_rising_b();
    run_stream(1'b0, '{21'h000001, 21'h100000, 21'h0C0C0C, 21'h1FFFFF},
               "R1 R2 R9 rising stream B");
  endtask

  task automatic test_falling();
    @(negedge clk_pix); #1 edge_sel = 1'b0;
    repeat (2) @(posedge clk_pix);
    run_stream(1'b1, '{21'h12345, 21'h0A5A5A, 21'h1C3C3C, 21'h00007F}, "R4 falling capture");
    @(negedge clk_pix); #1 edge_sel = 1'b1;
    repeat (2) @(posedge clk_pix);
  endtask

  task automatic test_power_down();
    logic [20:0] w;
    w = 21'h1B6DB6;
    @(negedge clk_pix); #2 din = w;
    repeat (3) @(posedge clk_pix);
    #20 pwr_on = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #7 check_low("R5 lanes low in power-down");
    end
    @(negedge clk_pix); #3 pwr_on = 1'b1;
    @(posedge clk_pix);
    check_frame('0, 7'd0, 16.5, "R5 first edge after release");
    check_frame(w, PAT, 5.0, "R5 second edge after release");
  endtask

  task automatic test_missing();
    logic [20:0] w;
    w = 21'h0F3C96;
    @(negedge clk_pix); #2 din = w;
    repeat (2) @(posedge clk_pix);
    @(negedge clk_raw); #1 pix_run = 1'b0;
    #80;
    for (int i = 0; i < 3; i++) begin
      check_low("R6 lanes low with pixel clock lost");
      #10;
    end
    repeat (3) @(negedge clk_raw);
    #1 pix_run = 1'b1;
    @(posedge clk_pix);
    check_frame('0, 7'd0, 16.5, "R7 first edge after loss");
    check_frame(w, PAT, 5.0, "R7 second edge after loss");
  endtask

  initial begin
    test_reset();
    repeat (3) @(posedge clk_pix);
    test_rising_a();
    test_rising_b();
    test_falling();
    test_power_down();
    test_missing();
    repeat (2) @(posedge clk_pix);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_bit);
    errors++;
    $display("FAIL watchdog expired got %0d exp %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule